// File: doc/BRIEF.md
# Daylight Saving Time Adjust Engine

This block sits beside a calendar time counter and decides when the clock has to jump for daylight saving time. It holds two rule sets. The forward rule says when to move the hour ahead by one. The reverse rule says when to move it back by one. On each advance strobe from the counter, the block compares the new calendar and time with both rules. When a rule matches, it raises a single-cycle request that the counter acts on.

Each rule gives a month and an hour, plus a day selector. The day selector works in one of two ways. It can name a fixed date. It can also name a weekday in a given week of the month, where the week is a number from 1 to 5 or a code meaning the last week. The hour field carries a 12/24-hour format flag, and this flag must agree with the counter's own format.

A global enable switches the whole function on or off. After a backward step, the hour that repeats would match the reverse rule a second time. A guard flag stops this second match. A small write port loads the eight rule bytes.

Top module: `dst_adjust`

## Requirements
- R1: After synchronous reset, `fwd_req` and `rev_req` are low, and they stay low until a matching strobe occurs.
- R2: The enable is bit 7 of rule byte index 0 and resets to 0. While it is 0, neither request is ever raised.
- R3: A forward match on a `tick` cycle raises `fwd_req` for exactly one cycle. The pulse appears one clock after the strobe.
- R4: A reverse match raises `rev_req` for one cycle, one clock after the strobe, and sets a guard. While the guard is set, no further reverse request is raised. The guard clears on the first strobe whose `cur_date` differs from the date at which the reverse request fired.
- R5: When the priority bit (bit 6 of rule byte index 1 or 5) is 0, the day matches when `cur_date` equals the BCD date held in bits 5:0 of byte index 2 or 6.
- R6: When the priority bit is 1 and the week field (bits 5:3) is N in 1..5, the day matches when `cur_wday` equals the weekday field (bits 2:0) and (date−1)/7+1 equals N.
- R7: When the priority bit is 1 and the week field is 7, the day matches on the selected weekday when date+7 exceeds the length of the month. February has 29 days when the binary value of `cur_year` is a multiple of 4, and 28 days otherwise.
- R8: When the priority bit is 1 and the week field is 0, the rule never matches.
- R9: The hour byte (index 3 or 7) is compared with `cur_hour` on bit 7, which is the 24-hour flag, and on bits 5:0. Bit 6 is ignored. If the format bits differ, no request is raised.
- R10: A rule is evaluated only while `tick` is high and `cur_min` and `cur_sec` are both zero.
- R11: Reset values are as follows:
  - Forward rule: month 04h, day byte 00h, date 01h, hour 02h.
  - Reverse rule: month 10h, day byte 00h, date 01h, hour 02h.

  With date priority, these fire on April 1 and October 1 at 2 AM in 12-hour format.
- R12: If both rules match on the same strobe, only `fwd_req` is raised, and the guard is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule byte write strobe |
| cfg_idx | input | 3 | Rule byte index: 0–3 forward month/day/date/hour, 4–7 reverse |
| cfg_wdata | input | 8 | Rule byte write data |
| tick | input | 1 | Advance strobe: the cur_* values are the new time |
| cur_sec | input | 7 | Seconds, BCD |
| cur_min | input | 7 | Minutes, BCD |
| cur_hour | input | 8 | Hour byte: bit 7 = 24-hour flag, bit 5 = PM in 12-hour mode, BCD hour |
| cur_wday | input | 3 | Day of week, 0 to 6 |
| cur_date | input | 6 | Date, BCD |
| cur_month | input | 5 | Month, BCD |
| cur_year | input | 8 | Year within century, BCD |
| fwd_req | output | 1 | One-cycle request to advance the hour by one |
| rev_req | output | 1 | One-cycle request to retard the hour by one |

## Verification
The assertions hold on every cycle for the following properties:
- the two requests are never high together;
- a request only follows an enabled strobe at minute and second zero;
- a forward request only follows a strobe whose format bit agrees with the rule;
- a reverse request always sets the guard and is never followed by a second pulse.

Some behaviour can only be shown by the bench's scenarios:
- the reset defaults;
- which calendar days the date, Nth-week and last-week selections pick, including leap and non-leap February;
- the week-off code;
- clearing of the guard when the date changes.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int NUM_RULES    = 2;
    localparam int BYTES_PER    = 4;
    localparam int NUM_BYTES    = NUM_RULES * BYTES_PER;
    localparam int IDX_W        = $clog2(NUM_BYTES);
    localparam int MONTH_W      = 5;
    localparam int DATE_W       = 6;
    localparam int WDAY_W       = 3;
    localparam int WEEK_W       = 3;
    localparam logic [WEEK_W-1:0] WEEK_LAST = 3'd7;
    localparam int RULE_FWD     = 0;
    localparam int RULE_REV     = 1;

    typedef struct packed {
        logic [MONTH_W-1:0] month;
        logic               prio;
        logic [WEEK_W-1:0]  week;
        logic [WDAY_W-1:0]  wday;
        logic [DATE_W-1:0]  date;
        logic [7:0]         hour;
    } rule_t;

    function automatic logic [7:0] byte_default(input int idx);
        case (idx)
            0:       return 8'h04;
            1:       return 8'h00;
            2:       return 8'h01;
            3:       return 8'h02;
            4:       return 8'h10;
            5:       return 8'h00;
            6:       return 8'h01;
            default: return 8'h02;
        endcase
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
    endfunction

    function automatic logic [5:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd2:                       return (yr[1:0] == 2'b00) ? 6'd29 : 6'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    return 6'd30;
            default:                    return 6'd31;
        endcase
    endfunction

endpackage

// File: rtl/dst_rule_regs.sv
module dst_rule_regs
    import dst_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic [7:0]                 wdata,
    output rule_t [NUM_RULES-1:0]      rules,
    output logic                       enable
);
    logic [7:0] bytes_q [NUM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BYTES; i++) bytes_q[i] <= byte_default(i);
        end else if (we) begin
            bytes_q[idx] <= wdata;
        end
    end

    genvar r;
    generate
        for (r = 0; r < NUM_RULES; r++) begin : g_unpack
            localparam int B = r * BYTES_PER;
            assign rules[r].month = bytes_q[B][MONTH_W-1:0];
            assign rules[r].prio  = bytes_q[B+1][6];
            assign rules[r].week  = bytes_q[B+1][5:3];
            assign rules[r].wday  = bytes_q[B+1][2:0];
            assign rules[r].date  = bytes_q[B+2][DATE_W-1:0];
            assign rules[r].hour  = bytes_q[B+3];
        end
    endgenerate

    assign enable = bytes_q[0][7];
endmodule

// File: rtl/dst_day_match.sv
module dst_day_match
    import dst_pkg::*;
(
    input  rule_t               rule,
    input  logic [WDAY_W-1:0]   cur_wday,
    input  logic [DATE_W-1:0]   cur_date,
    input  logic [MONTH_W-1:0]  cur_month,
    input  logic [7:0]          cur_year,
    output logic                day_hit
);
    logic [6:0] date_bin, mon_bin, yr_bin;
    logic [5:0] dim;
    logic [4:0] date_m1;
    logic [WEEK_W-1:0] week_now;
    logic is_last, wk_ok, by_wday, by_date;

    always_comb begin
        date_bin = bcd_to_bin({2'b00, cur_date});
        mon_bin  = bcd_to_bin({3'b000, cur_month});
        yr_bin   = bcd_to_bin(cur_year);
        dim      = month_len(mon_bin, yr_bin);
        date_m1  = date_bin[4:0] - 5'd1;
        week_now = WEEK_W'(date_m1 / 5'd7) + WEEK_W'(1);
        is_last  = (7'(date_bin) + 7'd7) > 7'(dim);
        if (rule.week == WEEK_LAST)      wk_ok = is_last;
        else if (rule.week == '0)        wk_ok = 1'b0;
        else                             wk_ok = (week_now == rule.week);
        by_wday  = wk_ok && (cur_wday == rule.wday);
        by_date  = (cur_date == rule.date);
        day_hit  = (cur_month == rule.month) && (rule.prio ? by_wday : by_date);
    end
endmodule

// File: rtl/dst_adjust.sv
module dst_adjust
    import dst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_idx,
    input  logic [7:0]           cfg_wdata,
    input  logic                 tick,
    input  logic [6:0]           cur_sec,
    input  logic [6:0]           cur_min,
    input  logic [7:0]           cur_hour,
    input  logic [2:0]           cur_wday,
    input  logic [5:0]           cur_date,
    input  logic [4:0]           cur_month,
    input  logic [7:0]           cur_year,
    output logic                 fwd_req,
    output logic                 rev_req
);
    rule_t [NUM_RULES-1:0] rules;
    logic                  dst_on;
    logic [NUM_RULES-1:0]  day_hit, hour_ok;
    logic                  on_hour, fire_f, fire_r;
    logic                  rev_done;
    logic [DATE_W-1:0]     done_date;
    logic [7:0]            fwd_hour_q;

    dst_rule_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .idx    (IDX_W'(cfg_idx)),
        .wdata  (cfg_wdata),
        .rules  (rules),
        .enable (dst_on)
    );

    genvar r;
    generate
        for (r = 0; r < NUM_RULES; r++) begin : g_rule
            dst_day_match u_day (
                .rule      (rules[r]),
                .cur_wday  (cur_wday),
                .cur_date  (cur_date),
                .cur_month (cur_month),
                .cur_year  (cur_year),
                .day_hit   (day_hit[r])
            );
            assign hour_ok[r] = ({cur_hour[7], cur_hour[5:0]} ==
                                 {rules[r].hour[7], rules[r].hour[5:0]});
        end
    endgenerate

    assign fwd_hour_q = rules[RULE_FWD].hour;

    always_comb begin
        on_hour = tick && (cur_min == '0) && (cur_sec == '0) && dst_on;
        fire_f  = on_hour && day_hit[RULE_FWD] && hour_ok[RULE_FWD];
        fire_r  = on_hour && day_hit[RULE_REV] && hour_ok[RULE_REV]
                  && !rev_done && !fire_f;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_req   <= 1'b0;
            rev_req   <= 1'b0;
            rev_done  <= 1'b0;
            done_date <= '0;
        end else begin
            fwd_req <= fire_f;
            rev_req <= fire_r;
            if (fire_r) begin
                rev_done  <= 1'b1;
                done_date <= cur_date;
            end else if (tick && (cur_date != done_date)) begin
                rev_done  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dst_adjust_chk.sv
module dst_adjust_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [6:0] cur_min,
    input logic [6:0] cur_sec,
    input logic [7:0] cur_hour,
    input logic       fwd_req,
    input logic       rev_req,
    input logic       dst_on,
    input logic [7:0] fwd_hour_cfg,
    input logic       rev_done
);
    p_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(fwd_req && rev_req));

    p_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (fwd_req || rev_req) |-> $past(dst_on));

    p_top_of_hour_r10: assert property (@(posedge clk) disable iff (rst)
        (fwd_req || rev_req) |-> $past(tick && cur_min == 7'd0 && cur_sec == 7'd0));

    p_format_r9: assert property (@(posedge clk) disable iff (rst)
        fwd_req |-> ($past(cur_hour[7]) == $past(fwd_hour_cfg[7])));

    p_rev_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rev_req |=> !rev_req);

    p_rev_guard_r4: assert property (@(posedge clk) disable iff (rst)
        rev_req |-> rev_done);
endmodule

bind dst_adjust dst_adjust_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .cur_min      (cur_min),
    .cur_sec      (cur_sec),
    .cur_hour     (cur_hour),
    .fwd_req      (fwd_req),
    .rev_req      (rev_req),
    .dst_on       (dst_on),
    .fwd_hour_cfg (fwd_hour_q),
    .rev_done     (rev_done)
);

// File: tb/dst_adjust_tb_top.sv
module dst_adjust_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0;
    logic [7:0] cur_hour = '0, cur_year = 8'h24;
    logic [2:0] cur_wday = '0;
    logic [5:0] cur_date = 6'h01;
    logic [4:0] cur_month = 5'h01;
    logic fwd_req, rev_req;
    logic got_f, got_r;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    dst_adjust dut_i (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(input logic [4:0] mo, input logic [5:0] dt, input logic [7:0] yr,
                        input logic [2:0] wd, input logic [7:0] hr,
                        input logic [6:0] mi, input logic [6:0] se, input logic tk);
        @(negedge clk);
        cur_month = mo; cur_date = dt; cur_year = yr; cur_wday = wd;
        cur_hour = hr; cur_min = mi; cur_sec = se; tick = tk;
        @(negedge clk);
        tick = 1'b0;
        got_f = fwd_req; got_r = rev_req;
    endtask

    task automatic t_reset;
        chk("R1 fwd idle after reset", fwd_req, 1'b0);
        chk("R1 rev idle after reset", rev_req, 1'b0);
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R2 disabled, fwd suppressed", got_f, 1'b0);
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R2 disabled, rev suppressed", got_r, 1'b0);
    endtask

    task automatic t_defaults;
        wr(3'd0, 8'h84);
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R11 default fwd Apr 1 2AM", got_f, 1'b1);
        @(negedge clk);
        chk("R3 fwd single cycle", fwd_req, 1'b0);
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R11 default rev Oct 1 2AM", got_r, 1'b1);
        chk("R4 rev not with fwd", got_f, 1'b0);
        @(negedge clk);
        chk("R4 rev single cycle", rev_req, 1'b0);
    endtask

    task automatic t_guard;
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R4 repeated hour blocked", got_r, 1'b0);
        step(5'h10, 6'h02, 8'h24, 3'd3, 8'h03, 7'h00, 7'h00, 1'b1);
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R4 guard cleared by date change", got_r, 1'b1);
    endtask

    task automatic t_minsec;
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h02, 7'h01, 7'h00, 1'b1);
        chk("R10 nonzero minute", got_f, 1'b0);
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h02, 7'h00, 7'h05, 1'b1);
        chk("R10 nonzero second", got_f, 1'b0);
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h02, 7'h00, 7'h00, 1'b0);
        chk("R10 no strobe", got_f, 1'b0);
    endtask

    task automatic t_format;
        wr(3'd3, 8'h82);
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R9 format mismatch", got_f, 1'b0);
        step(5'h04, 6'h01, 8'h24, 3'd1, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R9 format match 24h", got_f, 1'b1);
    endtask

    task automatic t_date_mode;
        wr(3'd0, 8'h83); wr(3'd1, 8'h07); wr(3'd2, 8'h15);
        step(5'h03, 6'h15, 8'h24, 3'd5, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R5 date match", got_f, 1'b1);
        step(5'h03, 6'h16, 8'h24, 3'd6, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R5 other date", got_f, 1'b0);
    endtask

    task automatic t_week_n;
        wr(3'd1, 8'h50);
        step(5'h03, 6'h10, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R6 2nd Sunday", got_f, 1'b1);
        step(5'h03, 6'h03, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R6 1st week", got_f, 1'b0);
        step(5'h03, 6'h15, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R6 3rd week", got_f, 1'b0);
        step(5'h03, 6'h10, 8'h24, 3'd1, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R6 wrong weekday", got_f, 1'b0);
    endtask

    task automatic t_last;
        wr(3'd1, 8'h78);
        step(5'h03, 6'h25, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R7 last week 31-day", got_f, 1'b1);
        step(5'h03, 6'h24, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R7 not last week", got_f, 1'b0);
        wr(3'd0, 8'h82);
        step(5'h02, 6'h23, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R7 leap Feb 23", got_f, 1'b1);
        step(5'h02, 6'h22, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R7 leap Feb 22", got_f, 1'b0);
        step(5'h02, 6'h22, 8'h23, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R7 non-leap Feb 22", got_f, 1'b1);
    endtask

    task automatic t_week_off;
        wr(3'd0, 8'h83); wr(3'd1, 8'h40);
        step(5'h03, 6'h01, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R8 week 0 off day1", got_f, 1'b0);
        step(5'h03, 6'h31, 8'h24, 3'd0, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R8 week 0 off day31", got_f, 1'b0);
    endtask

    task automatic t_enable_off;
        wr(3'd1, 8'h07); wr(3'd0, 8'h03);
        step(5'h03, 6'h15, 8'h24, 3'd5, 8'h82, 7'h00, 7'h00, 1'b1);
        chk("R2 enable cleared fwd", got_f, 1'b0);
        step(5'h10, 6'h05, 8'h24, 3'd6, 8'h05, 7'h00, 7'h00, 1'b1);
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R2 enable cleared rev", got_r, 1'b0);
    endtask

    task automatic t_both;
        wr(3'd0, 8'h90); wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd3, 8'h02);
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R12 fwd wins", got_f, 1'b1);
        chk("R12 rev held off", got_r, 1'b0);
        wr(3'd0, 8'h84);
        step(5'h10, 6'h01, 8'h24, 3'd2, 8'h02, 7'h00, 7'h00, 1'b1);
        chk("R12 guard untouched, rev fires", got_r, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_defaults;
        t_guard;
        t_minsec;
        t_format;
        t_date_mode;
        t_week_n;
        t_last;
        t_week_off;
        t_enable_off;
        t_both;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule